// File: doc/BRIEF.md
# I2C Register-File Target

This block is a serial-bus target that gives an external I2C master read and write access to a bank of sixteen 8-bit registers. It samples SCL and SDA on a fast system clock, recognises bus start, repeated start and stop conditions, compares the incoming address byte against a fixed 7-bit device address, and acknowledges by pulling SDA low through an open-drain enable.

A write transfer uses its first data byte to set an internal register pointer. Every later byte is stored at the register the pointer selects, and the pointer then advances. A read transfer streams registers out from wherever the pointer currently sits. Because the pointer survives stops, a master can set it in one write and fetch from it in a later read. The local host logic sees the same registers through a plain parallel port with a write strobe and an asynchronous read.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits are 1101000 (LSB: 0 = write, 1 = read). Any other address gets no acknowledge, and every later byte up to the next START is ignored: no acknowledge, no register change and no pointer change.
- R2: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. After a STOP, bits clocked without a new START get no response.
- R3: In a write, the first byte after the acknowledged address loads the pointer from its low 4 bits. Each later byte is stored in the register the pointer selects.
- R4: In a write, the address byte and every byte that follows are acknowledged: SDA is held low while SCL is high in the ninth clock.
- R5: The pointer advances by one after every data byte stored or sent, and wraps from 15 to 0.
- R6: A read returns the register at the pointer, most significant bit first, and goes on with the next register each time the master acknowledges.
- R7: When the master answers a read byte with a not-acknowledge, the target releases SDA and drives nothing until the next START.
- R8: The pointer is 0 after reset and keeps its value across STOP conditions.
- R9: A repeated START, without an intervening STOP, begins a new address phase.
- R10: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R11: All registers reset to 0. A host write stores `host_wdata` at `host_addr` on the clock edge, and `host_rdata` shows the register at `host_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at `host_addr` |

## Verification
On every cycle the assertions check the following: the open-drain enable only rises after SCL was low; the target is released whenever it is idle; STOP and START force the idle and address states; the pointer only ever holds or steps by one, except on a pointer load; and register writes happen only in write transfers. Only the bench's bus scenarios can show these behaviours: which address out of all 128 is answered, that data after a foreign address leaves registers and pointer untouched, that read data arrives MSB first and wraps, and that the pointer carries across stops and repeated starts.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ADDR     = 3'd1,
      ST_ACK_ADDR = 3'd2,
      ST_RX       = 3'd3,
      ST_ACK_RX   = 3'd4,
      ST_TX       = 3'd5,
      ST_MACK     = 3'd6
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_monitor.sv
// Synchronises SCL/SDA and derives edge and bus-condition strobes.
module i2c_line_monitor #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_line_monitor: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sync;
   logic [SYNC_STAGES-1:0] sda_sync;
   logic                   scl_d;
   logic                   sda_d;

   // Idle bus is high, so the chains reset to 1 to avoid a false edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sync <= '1;
         sda_sync <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
         sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
         scl_d    <= scl_sync[SYNC_STAGES-1];
         sda_d    <= sda_sync[SYNC_STAGES-1];
      end
   end

   assign scl_q     = scl_sync[SYNC_STAGES-1];
   assign sda_q     = sda_sync[SYNC_STAGES-1];
   assign scl_rise  =  scl_q & ~scl_d;
   assign scl_fall  = ~scl_q &  scl_d;
   assign start_det =  scl_q &  scl_d &  sda_d & ~sda_q;
   assign stop_det  =  scl_q &  scl_d & ~sda_d &  sda_q;

endmodule

// File: rtl/i2c_reg_bank.sv
// Register storage with a bus port (pointer-addressed) and a host port.
module i2c_reg_bank #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter bit HOST_RD_REG = 1'b0,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("i2c_reg_bank: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] regs [DEPTH];

   // A bus write wins over a host write to the same register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (bus_we && bus_addr == AW'(i))
               regs[i] <= bus_wdata;
            else if (host_we && host_addr == AW'(i))
               regs[i] <= host_wdata;
         end
      end
   end

   assign bus_rdata = regs[bus_addr];

   if (HOST_RD_REG) begin : g_host_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) host_rdata <= '0;
         else        host_rdata <= regs[host_addr];
      end
   end else begin : g_host_rd_comb
      assign host_rdata = regs[host_addr];
   end

endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level protocol engine: address match, pointer, shifting, ACK drive.
module i2c_target_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          PTR_W    = 4,
   parameter logic [6:0]  DEV_ADDR = 7'b1101000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  ptr,
   output logic              bus_we,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              ptr_load,
   output logic              rw,
   output logic              sda_oe,
   output tgt_state_e        state
);

   localparam int              CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("i2c_target_fsm: the address byte format needs DATA_W == 8");
   end
   if (PTR_W > DATA_W) begin : g_bad_ptr
      $error("i2c_target_fsm: PTR_W must fit in one data byte");
   end

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              byte_done;
   logic              first_q;
   logic              mack_q;
   logic              rx_close;

   // A received byte is closed out on the SCL fall after its 8th bit.
   assign rx_close  = (state == ST_RX) && scl_fall && byte_done;
   assign bus_we    = rx_close && !first_q;
   assign ptr_load  = rx_close &&  first_q;
   assign bus_wdata = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         first_q   <= 1'b0;
         mack_q    <= 1'b0;
         rw        <= 1'b0;
         ptr       <= '0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         byte_done <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_ADDR, ST_RX: begin
               if (scl_rise && !byte_done) begin
                  shreg <= {shreg[DATA_W-2:0], sda_q};
                  if (bit_cnt == LAST_BIT) begin
                     byte_done <= 1'b1;
                     bit_cnt   <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  if (state == ST_ADDR) begin
                     if (shreg[DATA_W-1:1] == DEV_ADDR) begin
                        rw      <= shreg[0];
                        first_q <= 1'b1;
                        sda_oe  <= 1'b1;
                        state   <= ST_ACK_ADDR;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     sda_oe  <= 1'b1;
                     first_q <= 1'b0;
                     state   <= ST_ACK_RX;
                     if (first_q) ptr <= shreg[PTR_W-1:0];
                     else         ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_ACK_ADDR: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rw) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                  end
               end
            end
            ST_ACK_RX: begin
               if (scl_fall) begin
                  sda_oe  <= 1'b0;
                  bit_cnt <= '0;
                  state   <= ST_RX;
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall) begin
                  if (bit_cnt == ALL_BITS) begin
                     sda_oe  <= 1'b0;
                     ptr     <= ptr + 1'b1;
                     bit_cnt <= '0;
                     state   <= ST_MACK;
                  end else begin
                     shreg  <= {shreg[DATA_W-2:0], 1'b0};
                     sda_oe <= ~shreg[DATA_W-2];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_q;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     state  <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
   import i2c_tgt_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         REG_DEPTH   = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b1101000,
   parameter bit         HOST_RD_REG = 1'b0,
   localparam int        PTR_W       = $clog2(REG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              host_we,
   input  logic [PTR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   logic              scl_q;
   logic              sda_q;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic [PTR_W-1:0]  ptr;
   logic              bus_we;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic              ptr_load;
   logic              rw;
   tgt_state_e        state;

   i2c_line_monitor #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_q    (scl_q),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_target_fsm #(
      .DATA_W  (DATA_W),
      .PTR_W   (PTR_W),
      .DEV_ADDR(DEV_ADDR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .rd_data  (bus_rdata),
      .ptr      (ptr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .ptr_load (ptr_load),
      .rw       (rw),
      .sda_oe   (sda_oe),
      .state    (state)
   );

   i2c_reg_bank #(
      .DATA_W     (DATA_W),
      .DEPTH      (REG_DEPTH),
      .HOST_RD_REG(HOST_RD_REG)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (ptr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
   import i2c_tgt_pkg::*;
#(
   parameter int PTR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_q,
   input logic             start_det,
   input logic             stop_det,
   input logic             sda_oe,
   input tgt_state_e       state,
   input logic [PTR_W-1:0] ptr,
   input logic             ptr_load,
   input logic             bus_we,
   input logic             rw
);

   AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_q)); // R10

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe); // R7

   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (state == ST_IDLE)); // R2

   AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR)); // R9

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_load |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1)); // R5

   AST_WRITE_IN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> (!rw && state == ST_RX)); // R3

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_q    (scl_q),
   .start_det(start_det),
   .stop_det (stop_det),
   .sda_oe   (sda_oe),
   .state    (state),
   .ptr      (ptr),
   .ptr_load (ptr_load),
   .bus_we   (bus_we),
   .rw       (rw)
);

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;

   localparam int Q = 5;
   localparam int H = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       host_we = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   wire        sda_bus = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;
   int oe_viol = 0;
   bit done = 1'b0;
   logic [7:0] mem [16];

   always #2.5 clk = ~clk;

   i2c_regfile_target uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_m),
      .sda_in    (sda_bus),
      .sda_oe    (sda_oe),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   // R10 monitor: the enable must not move while the master holds SCL high.
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
      oe_prev <= sda_oe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
   endtask

   task automatic sample_bit(output logic b);
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2); b = sda_bus; wt(H/2); scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      sample_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         sample_bit(b);
         v[i] = b;
      end
      send_bit(~ack);
   endtask

   task automatic host_read(input int idx, output logic [7:0] v);
      @(negedge clk);
      host_addr = 4'(idx);
      #1;
      v = host_rdata;
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 17 + 3) & 8'hFF);
   endfunction

   initial begin
      wt(150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] v;
      logic       b;
      int         zeros;

      wt(4);
      rst_n = 1'b1;
      wt(4);

      // Reset state: released line, all registers zero (R11)
      check(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
      for (int i = 0; i < 16; i++) begin
         host_read(i, v);
         check(v == 8'h00, "R11 reset register", v, 0);
      end

      // Host port writes a pattern and reads it back (R11)
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         host_we = 1'b1; host_addr = 4'(i); host_wdata = pat(i);
         mem[i] = pat(i);
      end
      @(negedge clk);
      host_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
         host_read(i, v);
         check(v == mem[i], "R11 host write/read", v, mem[i]);
      end

      // Read 17 bytes from the reset pointer: MSB first, wraps 15->0 (R6 R8 R5)
      bus_start();
      send_byte(8'hD1, ack);
      check(ack, "R1 read address ack", ack, 1);
      for (int i = 0; i < 17; i++) begin
         recv_byte(v, i != 16);
         check(v == mem[i % 16], "R6 R5 sequential read", v, mem[i % 16]);
      end
      bus_stop();
      // pointer now 1

      // Address sweep, write direction (R1)
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         check(ack == (a == 7'h68), "R1 address sweep", {a, ack}, {a, (a == 7'h68)});
         bus_stop();
      end

      // Write: pointer byte 0xFE -> 14, four data bytes wrap past 15 (R3 R4 R5)
      bus_start();
      send_byte(8'hD0, ack);
      check(ack, "R4 write address ack", ack, 1);
      send_byte(8'hFE, ack);
      check(ack, "R4 pointer byte ack", ack, 1);
      for (int i = 0; i < 4; i++) begin
         send_byte(8'hA1 + 8'(i * 17), ack);
         check(ack, "R4 data byte ack", ack, 1);
         mem[(14 + i) % 16] = 8'hA1 + 8'(i * 17);
      end
      bus_stop();
      for (int i = 0; i < 4; i++) begin
         host_read((14 + i) % 16, v);
         check(v == mem[(14 + i) % 16], "R3 R5 stored byte", v, mem[(14 + i) % 16]);
      end
      host_read(2, v);
      check(v == mem[2], "R3 neighbour untouched", v, mem[2]);

      // Read after STOP resumes at pointer 2; NACK releases the line (R8 R7)
      bus_start();
      send_byte(8'hD1, ack);
      recv_byte(v, 1'b0);
      check(v == mem[2], "R8 pointer kept across STOP", v, mem[2]);
      zeros = 0;
      for (int i = 0; i < 9; i++) begin
         sample_bit(b);
         if (!b) zeros++;
      end
      check(zeros == 0, "R7 silent after NACK", zeros, 0);
      bus_stop();
      bus_start();
      send_byte(8'hD1, ack);
      recv_byte(v, 1'b0);
      check(v == mem[3], "R5 read advanced pointer", v, mem[3]);
      bus_stop();
      // pointer now 4

      // Foreign address followed by bytes: all ignored (R1)
      bus_start();
      send_byte(8'hD2, ack);
      check(!ack, "R1 foreign address nack", ack, 0);
      send_byte(8'h07, ack);
      check(!ack, "R1 ignored byte nack", ack, 0);
      send_byte(8'h5A, ack);
      check(!ack, "R1 ignored byte nack", ack, 0);
      bus_stop();
      host_read(7, v);
      check(v == mem[7], "R1 register untouched", v, mem[7]);
      host_read(4, v);
      check(v == mem[4], "R1 register untouched", v, mem[4]);
      bus_start();
      send_byte(8'hD1, ack);
      recv_byte(v, 1'b0);
      check(v == mem[4], "R1 pointer untouched", v, mem[4]);
      bus_stop();
      // pointer now 5

      // Clocking a matching byte without START after STOP (R2)
      send_byte(8'hD0, ack);
      check(!ack, "R2 no START no response", ack, 0);
      bus_stop();

      // Repeated START: set pointer 9, write one byte, re-address as read (R9)
      bus_start();
      send_byte(8'hD0, ack);
      send_byte(8'h09, ack);
      send_byte(8'h3C, ack);
      mem[9] = 8'h3C;
      bus_start();
      send_byte(8'hD1, ack);
      check(ack, "R9 repeated START address ack", ack, 1);
      recv_byte(v, 1'b1);
      check(v == mem[10], "R9 read after repeated START", v, mem[10]);
      recv_byte(v, 1'b0);
      check(v == mem[11], "R9 second byte", v, mem[11]);
      bus_stop();
      host_read(9, v);
      check(v == 8'h3C, "R3 write before repeated START", v, 8'h3C);

      check(oe_viol == 0, "R10 sda_oe moved with SCL high", oe_viol, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule